// File: doc/BRIEF.md
# Group-to-Memory Crossbar Switch

This switch sits beside a single memory module. Many core groups send it request messages, and each group uses its own point-to-point channel. A message is 256 bits. It crosses a 64-bit channel as four beats in consecutive cycles. The switch rebuilds each message in a small queue kept for its group. A round-robin arbiter then picks one complete message at a time and streams its four beats to the one memory port, tagged with the index of the source group.

Responses come back from memory as four-beat messages. The low bits of the first beat carry the index of the group that made the request. The switch uses that index to send all four beats back down the reply channel of that group only.

Flow control runs on credits, and the credits never travel on a wire of their own. The switch keeps a count for each group of the queue slots it has freed since it last told that group. It writes up to three of those credits into a two-bit field in the first beat of each response it sends to the group. An upstream sender holds four credits after reset and spends one per message. If a message starts while its queue is already full, the switch drops the message and raises a sticky error flag for that group.

Top module: `grpmem_xbar`

## Requirements
- R1: During and right after reset, the switch drives no memory beats, no reply beats, and no error flags.
- R2: A group's four input beats leave on the memory port in the order they arrived, as four beats in consecutive cycles. The first beat is marked as first, the fourth as last, and every beat carries the group index. If the memory port is idle, the first beat appears in the second cycle after the clock edge that captures the fourth input beat.
- R3: Beats of different messages never interleave. After the last beat of a message, the memory port is idle for exactly one cycle.
- R4: Arbitration is round-robin over groups that hold a complete message. After reset, group 0 is searched first. After a grant to group g, the search starts at g+1 and wraps around.
- R5: Messages from one group reach the memory port in the order that group sent them.
- R6: The first beat of a response carries its destination group in bits [log2(groups)-1:0]. The switch delivers all four beats, one cycle after each arrives, on that group's reply channel and on no other.
- R7: In the first reply beat, the two bits just above the group field are replaced by min(pending, 3). Pending means messages dequeued for that group minus credits already returned to it. All other bits pass through unchanged.
- R8: Over a complete exchange, the credits returned to a group equal the messages it sent. A sender that starts with four credits and obeys them never causes a drop.
- R9: A message whose first beat arrives while its group's queue holds four complete messages is discarded in full, with none of its beats issued. That group's error flag is set and stays set until reset.
- R10: A dequeue for group g and a reply header to g can fall in the same cycle. In that cycle the header takes the credits counted before the dequeue, and the dequeue is added to pending rather than lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | NUM_GRP | Per-group request beat valid |
| req_beat | input | NUM_GRP*BEAT_W | Per-group request beat data, group g in slice g |
| mem_vld | output | 1 | Memory port beat valid |
| mem_first | output | 1 | First beat of the issued message |
| mem_last | output | 1 | Last beat of the issued message |
| mem_grp | output | log2(NUM_GRP) | Source group of the issued message |
| mem_beat | output | BEAT_W | Issued beat data |
| rsp_vld | input | 1 | Response beat valid from memory |
| rsp_beat | input | BEAT_W | Response beat data; first beat carries the group index |
| out_vld | output | NUM_GRP | Per-group reply beat valid |
| out_beat | output | NUM_GRP*BEAT_W | Per-group reply beat data with the credit field in the header |
| ovf_flag | output | NUM_GRP | Per-group sticky overflow flag |

## Verification
Two events can land in the same cycle: a group's queue is dequeued, and a reply header for that same group passes through the switch. Both change the group's pending credit count. The bench provokes the collision by timing a second message from one group so that it leaves its queue on exactly the edge where the response to the first message arrives. The fixed 100-cycle memory model in the bench makes that edge predictable. The bench then expects the two headers to carry one credit each. Losing the dequeue would give one and zero. Reading the count after the dequeue would give two and zero.

// File: rtl/grpmem_xbar_pkg.sv
package grpmem_xbar_pkg;

   localparam int unsigned CRED_W   = 2;
   localparam int unsigned CRED_MAX = (1 << CRED_W) - 1;

   function automatic int unsigned idx_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/grpmem_xbar_msgq.sv
module grpmem_xbar_msgq
   import grpmem_xbar_pkg::*;
#(
   parameter int unsigned BEAT_W = 64,
   parameter int unsigned BEATS  = 4,
   parameter int unsigned DEPTH  = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_vld,
   input  logic [BEAT_W-1:0]           in_beat,
   input  logic [idx_w(BEATS)-1:0]     rd_idx,
   input  logic                        pop,
   output logic [BEAT_W-1:0]           rd_beat,
   output logic                        has_msg,
   output logic                        ovf
);

   localparam int unsigned IW    = idx_w(BEATS);
   localparam int unsigned SW    = idx_w(DEPTH);
   localparam int unsigned CNT_W = SW + 1;
   localparam int unsigned CELLS = DEPTH * BEATS;

   logic [BEAT_W-1:0] store [CELLS];
   logic [SW-1:0]     wr_slot;
   logic [SW-1:0]     rd_slot;
   logic [IW-1:0]     wr_idx;
   logic [CNT_W-1:0]  count;
   logic              dropping;

   logic msg_start;
   logic q_full;
   logic discard;
   logic accept;
   logic push;

   always_comb begin
      msg_start = in_vld && (wr_idx == '0);
      q_full    = (count == CNT_W'(DEPTH));
      discard   = msg_start ? q_full : dropping;
      accept    = in_vld && !discard;
      push      = accept && (wr_idx == IW'(BEATS - 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_slot  <= '0;
         rd_slot  <= '0;
         wr_idx   <= '0;
         count    <= '0;
         dropping <= 1'b0;
         ovf      <= 1'b0;
      end else begin
         if (in_vld) begin
            wr_idx <= wr_idx + 1'b1;
         end
         if (msg_start) begin
            dropping <= q_full;
            if (q_full) begin
               ovf <= 1'b1;
            end
         end
         if (push) begin
            wr_slot <= wr_slot + 1'b1;
         end
         if (pop) begin
            rd_slot <= rd_slot + 1'b1;
         end
         count <= count + CNT_W'(push) - CNT_W'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (accept) begin
         store[{wr_slot, wr_idx}] <= in_beat;
      end
   end

   assign rd_beat = store[{rd_slot, rd_idx}];
   assign has_msg = (count != '0);

endmodule

// File: rtl/grpmem_xbar_arb.sv
module grpmem_xbar_arb
   import grpmem_xbar_pkg::*;
#(
   parameter int unsigned NUM_GRP = 16,
   parameter int unsigned BEATS   = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_GRP-1:0]            ready_q,
   output logic                          busy,
   output logic [idx_w(NUM_GRP)-1:0]     cur_grp,
   output logic [idx_w(BEATS)-1:0]       beat_idx,
   output logic                          first_beat,
   output logic                          last_beat,
   output logic [NUM_GRP-1:0]            pop
);

   localparam int unsigned GW = idx_w(NUM_GRP);
   localparam int unsigned IW = idx_w(BEATS);

   logic [GW-1:0] last_grant;
   logic [GW-1:0] winner;
   logic          found;

   always_comb begin
      logic [GW-1:0] probe;
      found  = 1'b0;
      winner = last_grant;
      for (int i = 1; i <= int'(NUM_GRP); i++) begin
         probe = last_grant + GW'(i);
         if (!found && ready_q[probe]) begin
            found  = 1'b1;
            winner = probe;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         cur_grp    <= '0;
         beat_idx   <= '0;
         last_grant <= GW'(NUM_GRP - 1);
      end else if (!busy) begin
         if (found) begin
            busy       <= 1'b1;
            cur_grp    <= winner;
            last_grant <= winner;
            beat_idx   <= '0;
         end
      end else begin
         beat_idx <= beat_idx + 1'b1;
         if (beat_idx == IW'(BEATS - 1)) begin
            busy <= 1'b0;
         end
      end
   end

   assign first_beat = busy && (beat_idx == '0);
   assign last_beat  = busy && (beat_idx == IW'(BEATS - 1));

   for (genvar g = 0; g < int'(NUM_GRP); g++) begin : g_pop
      assign pop[g] = last_beat && (cur_grp == GW'(g));
   end

endmodule

// File: rtl/grpmem_xbar_rsp.sv
module grpmem_xbar_rsp
   import grpmem_xbar_pkg::*;
#(
   parameter int unsigned NUM_GRP = 16,
   parameter int unsigned BEAT_W  = 64,
   parameter int unsigned BEATS   = 4,
   parameter int unsigned DEPTH   = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        rsp_vld,
   input  logic [BEAT_W-1:0]           rsp_beat,
   input  logic [NUM_GRP-1:0]          pop,
   output logic [NUM_GRP-1:0]          out_vld,
   output logic [NUM_GRP*BEAT_W-1:0]   out_beat
);

   localparam int unsigned GW = idx_w(NUM_GRP);
   localparam int unsigned IW = idx_w(BEATS);
   localparam int unsigned PW = idx_w(DEPTH) + 3;

   logic [IW-1:0]     rsp_idx;
   logic [GW-1:0]     hdr_grp_q;
   logic [PW-1:0]     pend [NUM_GRP];
   logic [BEAT_W-1:0] beat_q [NUM_GRP];

   logic              is_hdr;
   logic [GW-1:0]     sel;
   logic [PW-1:0]     pend_sel;
   logic [CRED_W-1:0] take;
   logic [BEAT_W-1:0] fwd_beat;

   always_comb begin
      is_hdr   = rsp_vld && (rsp_idx == '0);
      sel      = is_hdr ? rsp_beat[GW-1:0] : hdr_grp_q;
      pend_sel = pend[sel];
      take     = (pend_sel > PW'(CRED_MAX)) ? CRED_W'(CRED_MAX) : pend_sel[CRED_W-1:0];
      fwd_beat = rsp_beat;
      if (is_hdr) begin
         fwd_beat[GW +: CRED_W] = take;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_idx   <= '0;
         hdr_grp_q <= '0;
      end else if (rsp_vld) begin
         rsp_idx <= rsp_idx + 1'b1;
         if (is_hdr) begin
            hdr_grp_q <= rsp_beat[GW-1:0];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int g = 0; g < int'(NUM_GRP); g++) begin
            pend[g] <= '0;
         end
      end else begin
         for (int g = 0; g < int'(NUM_GRP); g++) begin
            pend[g] <= pend[g] + PW'(pop[g])
                     - ((is_hdr && (sel == GW'(g))) ? PW'(take) : PW'(0));
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld <= '0;
      end else begin
         for (int g = 0; g < int'(NUM_GRP); g++) begin
            out_vld[g] <= rsp_vld && (sel == GW'(g));
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int g = 0; g < int'(NUM_GRP); g++) begin
         if (rsp_vld && (sel == GW'(g))) begin
            beat_q[g] <= fwd_beat;
         end
      end
   end

   for (genvar g = 0; g < int'(NUM_GRP); g++) begin : g_out
      assign out_beat[g*BEAT_W +: BEAT_W] = beat_q[g];
   end

endmodule

// File: rtl/grpmem_xbar.sv
module grpmem_xbar
   import grpmem_xbar_pkg::*;
#(
   parameter int unsigned NUM_GRP = 16,
   parameter int unsigned BEAT_W  = 64,
   parameter int unsigned BEATS   = 4,
   parameter int unsigned DEPTH   = 4
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic [NUM_GRP-1:0]                    req_vld,
   input  logic [NUM_GRP*BEAT_W-1:0]             req_beat,
   output logic                                  mem_vld,
   output logic                                  mem_first,
   output logic                                  mem_last,
   output logic [grpmem_xbar_pkg::idx_w(NUM_GRP)-1:0] mem_grp,
   output logic [BEAT_W-1:0]                     mem_beat,
   input  logic                                  rsp_vld,
   input  logic [BEAT_W-1:0]                     rsp_beat,
   output logic [NUM_GRP-1:0]                    out_vld,
   output logic [NUM_GRP*BEAT_W-1:0]             out_beat,
   output logic [NUM_GRP-1:0]                    ovf_flag
);

   localparam int unsigned GW = idx_w(NUM_GRP);
   localparam int unsigned IW = idx_w(BEATS);

   if (NUM_GRP < 2 || !is_pow2(NUM_GRP)) begin : g_chk_grp
      $error("NUM_GRP must be a power of two of at least 2");
   end
   if (BEATS < 2 || !is_pow2(BEATS)) begin : g_chk_beats
      $error("BEATS must be a power of two of at least 2");
   end
   if (DEPTH < 2 || !is_pow2(DEPTH)) begin : g_chk_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (BEAT_W <= GW + CRED_W) begin : g_chk_width
      $error("BEAT_W too narrow for group and credit fields");
   end

   logic [NUM_GRP-1:0] q_has;
   logic [NUM_GRP-1:0] q_pop;
   logic [BEAT_W-1:0]  q_beat [NUM_GRP];
   logic [IW-1:0]      beat_idx;

   for (genvar g = 0; g < int'(NUM_GRP); g++) begin : g_q
      grpmem_xbar_msgq #(
         .BEAT_W (BEAT_W),
         .BEATS  (BEATS),
         .DEPTH  (DEPTH)
      ) u_q (
         .clk     (clk),
         .rst_n   (rst_n),
         .in_vld  (req_vld[g]),
         .in_beat (req_beat[g*BEAT_W +: BEAT_W]),
         .rd_idx  (beat_idx),
         .pop     (q_pop[g]),
         .rd_beat (q_beat[g]),
         .has_msg (q_has[g]),
         .ovf     (ovf_flag[g])
      );
   end

   grpmem_xbar_arb #(
      .NUM_GRP (NUM_GRP),
      .BEATS   (BEATS)
   ) u_arb (
      .clk        (clk),
      .rst_n      (rst_n),
      .ready_q    (q_has),
      .busy       (mem_vld),
      .cur_grp    (mem_grp),
      .beat_idx   (beat_idx),
      .first_beat (mem_first),
      .last_beat  (mem_last),
      .pop        (q_pop)
   );

   assign mem_beat = q_beat[mem_grp];

   grpmem_xbar_rsp #(
      .NUM_GRP (NUM_GRP),
      .BEAT_W  (BEAT_W),
      .BEATS   (BEATS),
      .DEPTH   (DEPTH)
   ) u_rsp (
      .clk      (clk),
      .rst_n    (rst_n),
      .rsp_vld  (rsp_vld),
      .rsp_beat (rsp_beat),
      .pop      (q_pop),
      .out_vld  (out_vld),
      .out_beat (out_beat)
   );

endmodule

// File: rtl/grpmem_xbar_chk.sv
module grpmem_xbar_chk #(
   parameter int unsigned NG = 16,
   parameter int unsigned GW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_vld,
   input logic          mem_first,
   input logic          mem_last,
   input logic [GW-1:0] mem_grp,
   input logic          rsp_vld,
   input logic [NG-1:0] out_vld,
   input logic [NG-1:0] ovf_flag
);

   assert_first_is_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_first |-> mem_vld);

   assert_start_marked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_vld) |-> mem_first);

   assert_no_interleave_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_vld && !mem_last) |=> (mem_vld && !mem_first && $stable(mem_grp)));

   assert_gap_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_last |=> !mem_vld);

   assert_single_route_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(out_vld));

   assert_reply_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_vld |=> (|out_vld));

   assert_no_idle_reply_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_vld |=> !(|out_vld));

   assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (|ovf_flag) |=> ((ovf_flag & $past(ovf_flag)) == $past(ovf_flag)));

endmodule

bind grpmem_xbar grpmem_xbar_chk #(.NG(NUM_GRP), .GW(GW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_vld   (mem_vld),
   .mem_first (mem_first),
   .mem_last  (mem_last),
   .mem_grp   (mem_grp),
   .rsp_vld   (rsp_vld),
   .out_vld   (out_vld),
   .ovf_flag  (ovf_flag)
);

// File: tb/grpmem_xbar_bench.sv
module grpmem_xbar_bench;

   localparam int CLK_PERIOD = 10;
   localparam int NG         = 4;
   localparam int BW         = 64;
   localparam int GW         = 2;
   localparam int MEM_LAT    = 100;
   localparam int WD_LIMIT   = 150000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NG-1:0]     req_vld = '0;
   logic [NG*BW-1:0]  req_beat = '0;
   logic              mem_vld, mem_first, mem_last;
   logic [GW-1:0]     mem_grp;
   logic [BW-1:0]     mem_beat;
   logic              rsp_vld = 1'b0;
   logic [BW-1:0]     rsp_beat = '0;
   logic [NG-1:0]     out_vld;
   logic [NG*BW-1:0]  out_beat;
   logic [NG-1:0]     ovf_flag;

   always #(CLK_PERIOD/2) clk = ~clk;

   grpmem_xbar #(.NUM_GRP(NG), .BEAT_W(BW), .BEATS(4), .DEPTH(4)) u_grpmem_xbar (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_beat(req_beat),
      .mem_vld(mem_vld), .mem_first(mem_first), .mem_last(mem_last),
      .mem_grp(mem_grp), .mem_beat(mem_beat), .rsp_vld(rsp_vld),
      .rsp_beat(rsp_beat), .out_vld(out_vld), .out_beat(out_beat),
      .ovf_flag(ovf_flag)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > WD_LIMIT) begin
         chk(1'b0, "R1", "watchdog expired", cyc, WD_LIMIT);
         finish_run();
      end
   end

   // bench state
   int  sent [NG];
   int  cred [NG];
   int  cred_sum [NG];
   int  crlog [NG][16];
   int  n_cr [NG];
   int  rb [NG];
   int  nxt_seq [NG];
   int  got [NG];
   int  order_log [64];
   int  n_order;
   int  exp_b;
   int  cur_g;
   bit  allow_gaps;

   // fixed-latency memory model
   logic          ml_v [MEM_LAT];
   logic          ml_f [MEM_LAT];
   logic [GW-1:0] ml_g [MEM_LAT];
   logic [BW-1:0] ml_d [MEM_LAT];
   int            ml_ptr;

   always @(negedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < MEM_LAT; i++) ml_v[i] = 1'b0;
         ml_ptr   = 0;
         rsp_vld  = 1'b0;
      end else begin
         rsp_vld  = ml_v[ml_ptr];
         rsp_beat = ml_f[ml_ptr] ? (ml_d[ml_ptr] | BW'(ml_g[ml_ptr])) : ml_d[ml_ptr];
         ml_v[ml_ptr] = mem_vld;
         ml_f[ml_ptr] = mem_first;
         ml_g[ml_ptr] = mem_grp;
         ml_d[ml_ptr] = {mem_beat[63:32], 32'h0};
         ml_ptr = (ml_ptr + 1) % MEM_LAT;
      end
   end

   // memory-port monitor
   always @(negedge clk) begin
      if (rst_n && mem_vld) begin
         int g, s, b;
         g = int'(mem_beat[63:56]);
         s = int'(mem_beat[55:40]);
         b = int'(mem_beat[39:32]);
         chk(b == exp_b, "R2", "beat order", b, exp_b);
         chk(mem_first == (exp_b == 0), "R2", "first marker", mem_first, exp_b == 0);
         chk(mem_last == (exp_b == 3), "R2", "last marker", mem_last, exp_b == 3);
         chk(g == int'(mem_grp), "R2", "group tag", mem_grp, g);
         if (exp_b == 0) begin
            cur_g = g;
            if (n_order < 64) order_log[n_order] = g;
            n_order++;
            if (allow_gaps) chk(s >= nxt_seq[g], "R5", "sequence order", s, nxt_seq[g]);
            else            chk(s == nxt_seq[g], "R5", "sequence order", s, nxt_seq[g]);
            nxt_seq[g] = s + 1;
            got[g]++;
         end else begin
            chk(g == cur_g, "R3", "interleaved beat", g, cur_g);
         end
         exp_b = (exp_b + 1) % 4;
      end
   end

   // reply monitor
   always @(negedge clk) begin
      if (rst_n) begin
         for (int g = 0; g < NG; g++) begin
            if (out_vld[g]) begin
               logic [BW-1:0] d;
               d = out_beat[g*BW +: BW];
               chk(int'(d[63:56]) == g, "R6", "reply routed to wrong group", d[63:56], g);
               chk(int'(d[39:32]) == rb[g], "R6", "reply beat order", d[39:32], rb[g]);
               if (rb[g] == 0) begin
                  chk(int'(d[GW-1:0]) == g, "R7", "header group field", d[GW-1:0], g);
                  chk(d[31:GW+2] == '0, "R7", "header other bits", d[31:GW+2], 0);
                  cred[g]     += int'(d[GW+1:GW]);
                  cred_sum[g] += int'(d[GW+1:GW]);
                  if (n_cr[g] < 16) crlog[g][n_cr[g]] = int'(d[GW+1:GW]);
                  n_cr[g]++;
               end else begin
                  chk(d[31:0] == '0, "R7", "body bits changed", d[31:0], 0);
               end
               rb[g] = (rb[g] + 1) % 4;
            end
         end
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n   = 1'b0;
      req_vld = '0;
      for (int g = 0; g < NG; g++) begin
         sent[g] = 0; cred[g] = 4; cred_sum[g] = 0; n_cr[g] = 0;
         rb[g] = 0; nxt_seq[g] = 0; got[g] = 0;
      end
      n_order = 0; exp_b = 0; cur_g = 0; allow_gaps = 1'b0;
      repeat (3) @(negedge clk);
      chk(mem_vld == 1'b0, "R1", "mem valid in reset", mem_vld, 0);
      chk(out_vld == '0, "R1", "reply valid in reset", out_vld, 0);
      chk(ovf_flag == '0, "R1", "overflow in reset", ovf_flag, 0);
      rst_n = 1'b1;
   endtask

   task automatic send_multi(input logic [NG-1:0] mask);
      for (int b = 0; b < 4; b++) begin
         @(negedge clk);
         for (int g = 0; g < NG; g++) begin
            req_vld[g] = mask[g];
            req_beat[g*BW +: BW] = {8'(g), 16'(sent[g]), 8'(b), 32'h0};
         end
      end
      @(negedge clk);
      req_vld = '0;
      for (int g = 0; g < NG; g++) if (mask[g]) sent[g]++;
   endtask

   initial begin
      // single message: latency and reset state
      do_reset();
      chk(mem_vld == 1'b0 && out_vld == '0, "R1", "idle after reset", {mem_vld, out_vld}, 0);
      send_multi(4'b0100);
      chk(mem_vld == 1'b0, "R2", "mem valid one cycle after last beat", mem_vld, 0);
      @(negedge clk);
      chk(mem_vld && mem_first && mem_grp == 2'd2, "R2", "issue two cycles after last beat",
          {mem_vld, mem_first, mem_grp}, {1'b1, 1'b1, 2'd2});
      repeat (140) @(negedge clk);
      chk(n_cr[2] == 1 && crlog[2][0] == 1, "R7", "single reply credit", crlog[2][0], 1);
      chk(ovf_flag == '0, "R8", "no overflow on single message", ovf_flag, 0);

      // round-robin order and piggybacked credits
      do_reset();
      send_multi(4'b1011);
      send_multi(4'b1011);
      repeat (160) @(negedge clk);
      chk(n_order == 6, "R4", "message count", n_order, 6);
      begin
         int exp_ord [6] = '{0, 1, 3, 0, 1, 3};
         for (int i = 0; i < 6; i++)
            chk(order_log[i] == exp_ord[i], "R4", "grant order", order_log[i], exp_ord[i]);
      end
      for (int g = 0; g < NG; g++) begin
         if (g != 2) begin
            chk(n_cr[g] == 2, "R6", "reply count", n_cr[g], 2);
            chk(crlog[g][0] == 2, "R7", "first reply credit", crlog[g][0], 2);
            chk(crlog[g][1] == 0, "R7", "second reply credit", crlog[g][1], 0);
         end
      end
      chk(n_cr[2] == 0, "R6", "no reply for silent group", n_cr[2], 0);

      // dequeue and reply header to the same group on the same edge
      do_reset();
      send_multi(4'b0010);
      repeat (MEM_LAT - 8) @(negedge clk);
      send_multi(4'b0010);
      repeat (250) @(negedge clk);
      chk(n_cr[1] == 2, "R10", "reply count", n_cr[1], 2);
      chk(crlog[1][0] == 1, "R10", "credit before same-cycle dequeue", crlog[1][0], 1);
      chk(crlog[1][1] == 1, "R10", "credit after same-cycle dequeue", crlog[1][1], 1);

      // credit-obeying senders
      do_reset();
      begin
         int left [NG];
         bit busy_any;
         for (int g = 0; g < NG; g++) left[g] = 10;
         busy_any = 1'b1;
         while (busy_any) begin
            logic [NG-1:0] m;
            m = '0;
            busy_any = 1'b0;
            for (int g = 0; g < NG; g++) begin
               if (left[g] > 0) busy_any = 1'b1;
               if (left[g] > 0 && cred[g] > 0) begin
                  m[g] = 1'b1; cred[g]--; left[g]--;
               end
            end
            if (m != '0) send_multi(m);
            else if (busy_any) @(negedge clk);
         end
         while (!(cred[0] == 4 && cred[1] == 4 && cred[2] == 4 && cred[3] == 4))
            @(negedge clk);
         repeat (10) @(negedge clk);
      end
      chk(ovf_flag == '0, "R8", "honest senders overflow", ovf_flag, 0);
      for (int g = 0; g < NG; g++) begin
         chk(got[g] == 10, "R5", "messages delivered", got[g], 10);
         chk(cred_sum[g] == 10, "R8", "credits returned", cred_sum[g], 10);
      end

      // senders that ignore credits
      do_reset();
      allow_gaps = 1'b1;
      repeat (8) send_multi(4'b1111);
      repeat (400) @(negedge clk);
      chk(ovf_flag == 4'b1111, "R9", "overflow flags", ovf_flag, 4'b1111);
      for (int g = 0; g < NG; g++) begin
         chk(got[g] >= 4 && got[g] <= 7, "R9", "delivered after drops", got[g], 4);
         chk(cred_sum[g] == got[g], "R8", "credits match accepted", cred_sum[g], got[g]);
      end
      repeat (20) @(negedge clk);
      chk(ovf_flag == 4'b1111, "R9", "flags stay set", ovf_flag, 4'b1111);
      do_reset();
      chk(ovf_flag == '0, "R9", "flags cleared by reset", ovf_flag, 0);

      finish_run();
   end

endmodule